// File: doc/BRIEF.md
# Shared-Bus Parallel EEPROM Write Sequencer

This controller programs a byte-wide parallel EEPROM from a stream of address/data byte pairs, using one 8-bit bus for both the address and the data. An external transparent latch holds the address for the memory. The controller opens the latch with its own enable output, lets it capture the address, closes it, and waits a settle interval. Only then does it switch the bus to the data byte and pulse the memory's active-low chip-enable and write-enable together for the byte-write time.

A `start` strobe begins a pass of `NUM_PAIRS` writes. Pairs come in over a valid/ready handshake, and the next pair is requested only once the current write pulse has ended. Output-enable stays inactive for the whole pass, so the memory never drives the shared bus. After the last write, a one-cycle `done` pulse is raised and the block goes back to idle. The latch-open time, the settle time and the write-pulse time are each a cycle-count parameter.

Top module: `mux_eeprom_writer`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, and `addr_le`, `pair_ready` and `done` are 0.
- R2: `mem_oe_n` is 1 in every cycle.
- R3: For each pair, `addr_le` is 1 for exactly `LATCH_CYC` consecutive cycles, and `shared_bus` carries the pair's address during that time.
- R4: `shared_bus` keeps the address in the cycle where `addr_le` falls and for `SETTLE_CYC` cycles in total, counted from that cycle.
- R5: `shared_bus` then carries the data byte for exactly `SETTLE_CYC` cycles, with `mem_ce_n` and `mem_we_n` still 1, before the write pulse begins.
- R6: `mem_ce_n` and `mem_we_n` fall and rise in the same cycles and stay 0 for exactly `WRITE_CYC` cycles. During the pulse `shared_bus` holds the data byte and `addr_le` is 0. The memory then holds that byte at the latched address.
- R7: `pair_ready` is 1 only while the block waits for a pair. It rises in the same cycle the write pulse ends (except after the last pair), and it falls in the cycle after a pair is accepted (`pair_valid` and `pair_ready` both 1 at a clock edge).
- R8: After `NUM_PAIRS` writes, `done` is 1 for exactly one cycle, in the cycle where the last write pulse ends. The block then idles with `pair_ready` 0 and the strobes high. A `start` during a pass has no effect.
- R9: While `pair_ready` is 1 and `pair_valid` is 0, the block holds `addr_le` at 0 and the strobes at 1 and keeps waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a pass of NUM_PAIRS writes when idle |
| pair_addr | input | BUS_W | Address byte of the offered pair |
| pair_data | input | BUS_W | Data byte of the offered pair |
| pair_valid | input | 1 | A pair is offered |
| pair_ready | output | 1 | Controller accepts a pair this cycle |
| shared_bus | output | BUS_W | Multiplexed address/data bus to latch and memory |
| addr_le | output | 1 | Address latch enable, 1 = transparent |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| done | output | 1 | One-cycle pulse after the last write of a pass |

## Verification
The bench keeps `NUM_PAIRS` at its full value of 256. It cuts the phase counts to `LATCH_CYC`=3, `SETTLE_CYC`=2 and `WRITE_CYC`=6, so two complete passes of 256 writes with different address permutations fit in a few thousand cycles. With such short phases, every per-cycle window boundary of latch, settle, data setup and write pulse is measured on each write. The last-pair decision, the done pulse and the restart after a pass are also reached twice. A behavioural transparent latch and memory confirm that every pair lands at its own address.

// File: rtl/eew_pkg.sv
package eew_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LE_OPEN,
        ST_ADDR_HOLD,
        ST_DATA_SETUP,
        ST_WRITE,
        ST_DONE
    } eew_state_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/eew_phase_timer.sv
module eew_phase_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/eew_pair_counter.sv
module eew_pair_counter #(
    parameter int unsigned NUM_PAIRS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic is_last
);
    localparam int unsigned PW = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
    localparam logic [PW-1:0] LAST_IDX = PW'(NUM_PAIRS - 1);

    logic [PW-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clear)    idx_d = '0;
        else if (inc) idx_d = idx_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign is_last = (idx_q == LAST_IDX);
endmodule

// File: rtl/mux_eeprom_writer.sv
module mux_eeprom_writer
    import eew_pkg::*;
#(
    parameter int unsigned BUS_W      = 8,
    parameter int unsigned NUM_PAIRS  = 256,
    parameter int unsigned LATCH_CYC  = 250,
    parameter int unsigned SETTLE_CYC = 50,
    parameter int unsigned WRITE_CYC  = 2500000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BUS_W-1:0] pair_addr,
    input  logic [BUS_W-1:0] pair_data,
    input  logic             pair_valid,
    output logic             pair_ready,
    output logic [BUS_W-1:0] shared_bus,
    output logic             addr_le,
    output logic             mem_ce_n,
    output logic             mem_we_n,
    output logic             mem_oe_n,
    output logic             done
);
    localparam int unsigned MAXC = max3(LATCH_CYC, SETTLE_CYC, WRITE_CYC);
    localparam int unsigned TW   = $clog2(MAXC + 1) + 1;
    localparam logic [TW-1:0] LATCH_LD  = TW'(LATCH_CYC - 1);
    localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] WRITE_LD  = TW'(WRITE_CYC - 1);

    typedef struct packed {
        eew_state_e       state;
        logic [BUS_W-1:0] bus;
        logic [BUS_W-1:0] data;
        logic             le;
        logic             ce_n;
        logic             we_n;
        logic             ready;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;
    logic          cnt_clear;
    logic          cnt_inc;
    logic          cnt_last;

    eew_phase_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    eew_pair_counter #(.NUM_PAIRS(NUM_PAIRS)) u_pairs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .inc     (cnt_inc),
        .is_last (cnt_last)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        cnt_clear = 1'b0;
        cnt_inc   = 1'b0;

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.state = ST_FETCH;
                    ctl_d.ready = 1'b1;
                    cnt_clear   = 1'b1;
                end
            end
            ST_FETCH: begin
                if (pair_valid) begin
                    ctl_d.ready = 1'b0;
                    ctl_d.bus   = pair_addr;
                    ctl_d.data  = pair_data;
                    ctl_d.le    = 1'b1;
                    ctl_d.state = ST_LE_OPEN;
                    tmr_load    = 1'b1;
                    tmr_val     = LATCH_LD;
                end
            end
            ST_LE_OPEN: begin
                if (tmr_expired) begin
                    ctl_d.le    = 1'b0;
                    ctl_d.state = ST_ADDR_HOLD;
                    tmr_load    = 1'b1;
                    tmr_val     = SETTLE_LD;
                end
            end
            ST_ADDR_HOLD: begin
                if (tmr_expired) begin
                    ctl_d.bus   = ctl_q.data;
                    ctl_d.state = ST_DATA_SETUP;
                    tmr_load    = 1'b1;
                    tmr_val     = SETTLE_LD;
                end
            end
            ST_DATA_SETUP: begin
                if (tmr_expired) begin
                    ctl_d.ce_n  = 1'b0;
                    ctl_d.we_n  = 1'b0;
                    ctl_d.state = ST_WRITE;
                    tmr_load    = 1'b1;
                    tmr_val     = WRITE_LD;
                end
            end
            ST_WRITE: begin
                if (tmr_expired) begin
                    ctl_d.ce_n = 1'b1;
                    ctl_d.we_n = 1'b1;
                    if (cnt_last) begin
                        ctl_d.state = ST_DONE;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.state = ST_FETCH;
                        ctl_d.ready = 1'b1;
                        cnt_inc     = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                ctl_d.state = ST_IDLE;
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.bus   <= '0;
            ctl_q.data  <= '0;
            ctl_q.le    <= 1'b0;
            ctl_q.ce_n  <= 1'b1;
            ctl_q.we_n  <= 1'b1;
            ctl_q.ready <= 1'b0;
            ctl_q.done  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pair_ready = ctl_q.ready;
    assign shared_bus = ctl_q.bus;
    assign addr_le    = ctl_q.le;
    assign mem_ce_n   = ctl_q.ce_n;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_oe_n   = 1'b1;
    assign done       = ctl_q.done;
endmodule

// File: rtl/eew_checker.sv
module eew_checker #(
    parameter int unsigned BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [BUS_W-1:0] shared_bus,
    input logic             addr_le,
    input logic             mem_ce_n,
    input logic             mem_we_n,
    input logic             mem_oe_n,
    input logic             pair_ready,
    input logic             done
);
    a_r2_oe_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        mem_oe_n == 1'b1);

    a_r6_strobes_paired: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n == mem_we_n);

    a_r6_latch_closed_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !addr_le);

    a_r4_bus_held_at_close: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_le) |-> $stable(shared_bus));

    a_r6_bus_steady_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(shared_bus));

    a_r7_ready_only_when_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ready |-> (mem_ce_n && !addr_le));

    a_r8_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_ce_n && !pair_ready));
endmodule

bind mux_eeprom_writer eew_checker #(.BUS_W(BUS_W)) u_eew_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .shared_bus (shared_bus),
    .addr_le    (addr_le),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .pair_ready (pair_ready),
    .done       (done)
);

// File: tb/mux_eeprom_writer_tb_top.sv
`timescale 1ns/1ps
module mux_eeprom_writer_tb_top;
    localparam int BW  = 8;
    localparam int NP  = 256;
    localparam int LAT = 3;
    localparam int SET = 2;
    localparam int WR  = 6;

    typedef struct { logic [7:0] a; logic [7:0] d; } pair_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [BW-1:0] pair_addr = '0;
    logic [BW-1:0] pair_data = '0;
    logic pair_valid = 1'b0;
    logic pair_ready, addr_le, mem_ce_n, mem_we_n, mem_oe_n, done;
    logic [BW-1:0] shared_bus;

    int tests = 0;
    int fails = 0;
    pair_t sb[$];
    logic [7:0] mem [256];
    logic [7:0] lat_q;
    int done_cnt = 0;
    int writes = 0;

    always #2 clk = ~clk;

    mux_eeprom_writer #(
        .BUS_W(BW), .NUM_PAIRS(NP), .LATCH_CYC(LAT), .SETTLE_CYC(SET), .WRITE_CYC(WR)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pair_addr(pair_addr), .pair_data(pair_data), .pair_valid(pair_valid),
        .pair_ready(pair_ready), .shared_bus(shared_bus), .addr_le(addr_le),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .done(done)
    );

    // behavioural transparent latch and memory
    always_latch begin
        if (addr_le) lat_q = shared_bus;
    end

    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n === 1'b0) mem[lat_q] = shared_bus;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // monitor: window measurement and scoreboard
    logic prev_le = 1'b0, prev_ce = 1'b1, prev_done = 1'b0;
    int le_run = 0, post_run = 0, wr_run = 0;
    bit in_post = 0;
    int oe_bad = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_oe_n !== 1'b1) oe_bad++;
            if (addr_le) begin
                le_run++;
                if (sb.size() > 0) chk(shared_bus == sb[0].a, "R3 addr on bus", shared_bus, sb[0].a);
            end
            if (prev_le && !addr_le) begin
                chk(le_run == LAT, "R3 latch-open width", le_run, LAT);
                le_run = 0; in_post = 1; post_run = 0;
            end
            if (in_post && mem_ce_n && !addr_le) begin
                post_run++;
                if (post_run <= SET) chk(shared_bus == sb[0].a, "R4 addr hold", shared_bus, sb[0].a);
                else                 chk(shared_bus == sb[0].d, "R5 data setup", shared_bus, sb[0].d);
            end
            if (prev_ce && !mem_ce_n) begin
                chk(post_run == 2*SET, "R5 settle windows", post_run, 2*SET);
                in_post = 0; wr_run = 0;
            end
            if (!mem_ce_n) begin
                wr_run++;
                chk(mem_we_n == 1'b0 && !addr_le && shared_bus == sb[0].d, "R6 write pulse",
                    {mem_we_n, addr_le, shared_bus}, {2'b00, sb[0].d});
            end
            if (!prev_ce && mem_ce_n) begin
                pair_t e;
                e = sb.pop_front();
                writes++;
                chk(wr_run == WR, "R6 write width", wr_run, WR);
                chk(mem[e.a] == e.d, "R6 memory content", mem[e.a], e.d);
                if (writes % NP == 0) chk(done == 1'b1 && pair_ready == 1'b0, "R8 done at last", {done, pair_ready}, 2'b10);
                else                  chk(pair_ready == 1'b1 && done == 1'b0, "R7 ready after write", {pair_ready, done}, 2'b10);
            end
            if (done) done_cnt++;
            if (prev_done && done) chk(0, "R8 done width", 2, 1);
            prev_le = addr_le; prev_ce = mem_ce_n; prev_done = done;
        end
    end

    task automatic run_pass(input logic [7:0] seed, input int exp_done);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < NP; i++) begin
            pair_t p;
            while (!pair_ready) @(negedge clk);
            if (i % 7 == 3) begin
                repeat (3) @(negedge clk);
                chk(pair_ready && !addr_le && mem_ce_n && mem_we_n, "R9 stall holds",
                    {pair_ready, addr_le, mem_ce_n, mem_we_n}, 4'b1011);
            end
            p.a = 8'(i) ^ seed;
            p.d = 8'(i * 29) + seed;
            sb.push_back(p);
            pair_addr = p.a; pair_data = p.d; pair_valid = 1'b1;
            @(negedge clk);
            pair_valid = 1'b0;
            chk(pair_ready == 1'b0 && addr_le == 1'b1, "R7 accept drops ready", {pair_ready, addr_le}, 2'b01);
            if (i == 100) begin
                start = 1'b1; @(negedge clk); start = 1'b0;
            end
        end
        while (done_cnt < exp_done) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(done_cnt == exp_done, "R8 one done per pass", done_cnt, exp_done);
        chk(!pair_ready && mem_ce_n && mem_we_n && !addr_le, "R8 idle after pass",
            {pair_ready, mem_ce_n, mem_we_n, addr_le}, 4'b0110);
        for (int i = 0; i < NP; i++) begin
            logic [7:0] a;
            a = 8'(i) ^ seed;
            chk(mem[a] == 8'(i * 29) + seed, "R6 image", mem[a], 8'(i * 29) + seed);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n && !addr_le && !pair_ready && !done, "R1 in reset",
            {mem_ce_n, mem_we_n, mem_oe_n, addr_le, pair_ready, done}, 6'b111000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n && !addr_le && !pair_ready && !done, "R1 after reset",
            {mem_ce_n, mem_we_n, mem_oe_n, addr_le, pair_ready, done}, 6'b111000);
        run_pass(8'h00, 1);
        run_pass(8'hA5, 2);
        chk(oe_bad == 0, "R2 oe held high", oe_bad, 0);
        chk(sb.size() == 0, "R7 scoreboard drained", sb.size(), 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end
endmodule